// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a simple on-chip request port and an external asynchronous static RAM of 65,536 four-bit words. A client presents a request with a valid/ready handshake, a write flag, a 16-bit word address and 4 bits of write data. The controller then runs one complete memory cycle. It drives the active-low chip select, output enable and write enable strobes, and it drives the shared 4-bit data bus through separate data-out, data-in and drive-enable pins.

Each analog timing minimum of the memory is given as a clock-cycle count: write pulse width, data setup before the end of a write, read access, and bus release after a read. Each count is the nanosecond minimum divided by the clock period, rounded up. The controller accepts one request at a time and holds ready low until the access and any turnaround after it are complete. Read data comes back with a single-cycle valid strobe.

With no request pending, the controller keeps chip select high so the memory stays in standby.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all 1, `mem_dq_oe` is 0 and `rd_valid` is 0.
- R2: After a read is accepted (`req_valid` and `req_ready` both 1 at a rising edge, `req_write` = 0), the memory side shows `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for exactly `T_RD` cycles, with `mem_addr` equal to the accepted address.
- R3: Read data is sampled from `mem_dq_in` in the last of the `T_RD` read cycles. In the next cycle only, `rd_valid` is 1 and `rd_data` holds the sampled value.
- R4: After a write is accepted (`req_write` = 1), the controller first spends `T_DS` cycles with `mem_cs_n`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=1, with `mem_dq_out` carrying the accepted data. It then spends `T_WP` cycles with `mem_we_n`=0 and everything else unchanged. After that, all strobes return to 1 and `mem_dq_oe` returns to 0.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. Whenever `mem_we_n` is 0, both `mem_dq_oe` is 1 and `mem_cs_n` is 0.
- R6: Every read is followed by `T_TURN` cycles in which `mem_cs_n`=1 and `mem_dq_oe`=0, before any further access can begin.
- R7: `req_ready` is 1 exactly when the controller is idle. It is 0 from the cycle after acceptance until the access, including any read turnaround, has ended. A request presented while `req_ready` is 0 is ignored.
- R8: `mem_addr` and `mem_dq_out` keep the values captured at acceptance for the whole access, even if `req_addr`, `req_wdata` or `req_write` change during it.
- R9: With no request pending, the controller stays idle with `mem_cs_n`=1, so the memory is in standby.
- R10: `mem_we_n` and `mem_oe_n` are never both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle strobe marking read data |
| rd_data | output | 4 | Read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 16 | Memory address bus |
| mem_dq_out | output | 4 | Data driven toward the memory |
| mem_dq_in | input | 4 | Data returned from the memory pins |
| mem_dq_oe | output | 1 | Enables the data-bus pad drivers |

## Verification
Several properties are checked by assertions on every cycle:
- the bus is never driven against an enabled memory output, and output enable and write enable are never low together;
- the write-enable pulse lasts exactly the pulse count, and the bus is driven for exactly the setup count before it;
- the address does not move while chip select is held low;
- ready implies standby, and the read strobe is a single-cycle pulse that follows an output-enable window.

Other behaviour can only be shown by the directed scenarios: the read-wait and turnaround lengths, the sampling of data in the final read cycle, the request inputs being ignored mid-access, and data written and later read back at distinct addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_WAIT  = 3'd1,
      ST_RD_TURN  = 3'd2,
      ST_WR_SETUP = 3'd3,
      ST_WR_PULSE = 3'd4
   } ctrl_state_e;

   typedef struct packed {
      logic cs_n;
      logic oe_n;
      logic we_n;
      logic drive;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

   // Memory-side strobe pattern for each controller state
   function automatic strobe_t state_strobes(ctrl_state_e st);
      strobe_t s;
      s = STROBE_IDLE;
      case (st)
         ST_RD_WAIT: begin
            s.cs_n = 1'b0;
            s.oe_n = 1'b0;
         end
         ST_WR_SETUP: begin
            s.cs_n  = 1'b0;
            s.drive = 1'b1;
         end
         ST_WR_PULSE: begin
            s.cs_n  = 1'b0;
            s.we_n  = 1'b0;
            s.drive = 1'b1;
         end
         default: s = STROBE_IDLE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int T_WP        = 2,
   parameter int T_DS        = 2,
   parameter int T_RD        = 3,
   parameter int T_TURN      = 2,
   parameter int CNT_W       = 3,
   parameter bit REG_STROBES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             timer_last,
   output logic             idle,
   output logic             accept,
   output logic             capture,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val,
   output strobe_t          strobes
);

   ctrl_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      capture = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_WAIT;
         end
         ST_RD_WAIT: begin
            if (timer_last) begin
               state_d = ST_RD_TURN;
               capture = 1'b1;
            end
         end
         ST_RD_TURN:  if (timer_last) state_d = ST_IDLE;
         ST_WR_SETUP: if (timer_last) state_d = ST_WR_PULSE;
         ST_WR_PULSE: if (timer_last) state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      case (state_d)
         ST_RD_WAIT:  timer_val = CNT_W'(T_RD);
         ST_RD_TURN:  timer_val = CNT_W'(T_TURN);
         ST_WR_SETUP: timer_val = CNT_W'(T_DS);
         ST_WR_PULSE: timer_val = CNT_W'(T_WP);
         default:     timer_val = '0;
      endcase
   end

   assign timer_load = (state_d != state_q);
   assign idle       = (state_q == ST_IDLE);
   assign accept     = idle && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   generate
      if (REG_STROBES) begin : g_reg_strobes
         strobe_t strobes_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobes_q <= STROBE_IDLE;
            else        strobes_q <= state_strobes(state_d);
         end
         assign strobes = strobes_q;
      end else begin : g_dec_strobes
         assign strobes = state_strobes(state_q);
      end
   endgenerate

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= capture;
         if (capture) rd_data <= mem_dq_in;
      end
   end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 4,
   parameter int T_WP        = 2,
   parameter int T_DS        = 2,
   parameter int T_RD        = 3,
   parameter int T_TURN      = 2,
   parameter bit REG_STROBES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int MAX_A = (T_WP > T_DS) ? T_WP : T_DS;
   localparam int MAX_B = (T_RD > T_TURN) ? T_RD : T_TURN;
   localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = $clog2(MAX_T + 1);

   generate
      if (T_WP < 1)   begin : g_bad_wp   $error("T_WP must be at least 1");   end
      if (T_DS < 1)   begin : g_bad_ds   $error("T_DS must be at least 1");   end
      if (T_RD < 1)   begin : g_bad_rd   $error("T_RD must be at least 1");   end
      if (T_TURN < 1) begin : g_bad_turn $error("T_TURN must be at least 1"); end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w $error("widths must be positive"); end
   endgenerate

   logic             accept;
   logic             capture;
   logic             timer_load;
   logic [CNT_W-1:0] timer_val;
   logic             timer_last;
   strobe_t          strobes;

   sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (timer_val),
      .last     (timer_last)
   );

   sram_ctrl_seq #(
      .T_WP        (T_WP),
      .T_DS        (T_DS),
      .T_RD        (T_RD),
      .T_TURN      (T_TURN),
      .CNT_W       (CNT_W),
      .REG_STROBES (REG_STROBES)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .timer_last (timer_last),
      .idle       (req_ready),
      .accept     (accept),
      .capture    (capture),
      .timer_load (timer_load),
      .timer_val  (timer_val),
      .strobes    (strobes)
   );

   sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_in (mem_dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   assign mem_cs_n  = strobes.cs_n;
   assign mem_oe_n  = strobes.oe_n;
   assign mem_we_n  = strobes.we_n;
   assign mem_dq_oe = strobes.drive;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
   parameter int ADDR_W = 16,
   parameter int T_WP   = 2,
   parameter int T_DS   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);

   logic [15:0] we_low_cnt;
   logic [15:0] setup_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt <= '0;
         setup_cnt  <= '0;
      end else begin
         we_low_cnt <= !mem_we_n ? we_low_cnt + 16'd1 : 16'd0;
         setup_cnt  <= (mem_dq_oe && mem_we_n) ? setup_cnt + 16'd1 : 16'd0;
      end
   end

   assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   assert_write_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

   assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   assert_we_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt == 16'(T_WP)));

   assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (setup_cnt == 16'(T_DS)));

   assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n ##1 !mem_cs_n) |-> $stable(mem_addr));

   assert_ready_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && !mem_dq_oe));

   assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

endmodule

bind sram_cycle_ctrl sram_ctrl_checker #(
   .ADDR_W (ADDR_W),
   .T_WP   (T_WP),
   .T_DS   (T_DS)
) i_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .mem_cs_n  (mem_cs_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;

   localparam int T_WP   = 2;
   localparam int T_DS   = 2;
   localparam int T_RD   = 3;
   localparam int T_TURN = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        rd_valid;
   logic [3:0]  rd_data;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [15:0] mem_addr;
   logic [3:0]  mem_dq_out;
   logic [3:0]  mem_dq_in;

   int checks = 0;
   int errors = 0;

   logic [3:0] mem_model [256];
   logic [3:0] exp_mem   [256];
   int         oe_cycles = 0;

   always #2.5 clk = ~clk;

   sram_cycle_ctrl #(
      .T_WP(T_WP), .T_DS(T_DS), .T_RD(T_RD), .T_TURN(T_TURN)
   ) i_sram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
      .mem_dq_oe(mem_dq_oe)
   );

   // Memory model: data turns valid only in the T_RD-th cycle of output enable
   always @(posedge clk) begin
      oe_cycles <= (!mem_cs_n && !mem_oe_n) ? oe_cycles + 1 : 0;
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem_model[mem_addr[7:0]] <= mem_dq_out;
   end

   assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && oe_cycles >= T_RD - 1)
                      ? mem_model[mem_addr[7:0]] : ~mem_model[mem_addr[7:0]];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic check_idle(input string req);
      chk(mem_cs_n && mem_oe_n && mem_we_n, req, "strobes idle",
          {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
      chk(!mem_dq_oe, req, "bus released", mem_dq_oe, 0);
      chk(req_ready, req, "ready in idle", req_ready, 1);
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_idle("R1");
      chk(!rd_valid, "R1", "rd_valid in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");
      chk(!rd_valid, "R1", "rd_valid after reset", rd_valid, 0);
   endtask

   task automatic do_write(input logic [15:0] addr, input logic [3:0] data, input bit junk);
      @(negedge clk);
      chk(req_ready, "R7", "ready before write", req_ready, 1);
      req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = data;
      @(negedge clk);
      for (int c = 1; c <= T_DS; c++) begin
         if (c == 1) begin
            req_valid = junk; req_write = 1'b0; req_addr = ~addr; req_wdata = ~data;
         end
         chk(!mem_cs_n && mem_we_n && mem_oe_n, "R4", "setup strobes",
             {mem_cs_n, mem_oe_n, mem_we_n}, 3'b011);
         chk(mem_dq_oe && mem_dq_out == data, "R4", "setup data", mem_dq_out, data);
         chk(mem_addr == addr, "R8", "write address held", mem_addr, addr);
         chk(!req_ready, "R7", "ready low in write", req_ready, 0);
         @(negedge clk);
      end
      for (int c = 1; c <= T_WP; c++) begin
         chk(!mem_cs_n && !mem_we_n && mem_oe_n, "R4", "pulse strobes",
             {mem_cs_n, mem_oe_n, mem_we_n}, 3'b010);
         chk(mem_dq_oe && mem_dq_out == data, "R8", "pulse data held", mem_dq_out, data);
         chk(mem_addr == addr, "R8", "pulse address held", mem_addr, addr);
         if (c == T_WP) req_valid = 1'b0;
         @(negedge clk);
      end
      check_idle("R4");
      exp_mem[addr[7:0]] = data;
   endtask

   task automatic do_read(input logic [15:0] addr, input bit junk);
      logic [3:0] exp;
      exp = exp_mem[addr[7:0]];
      @(negedge clk);
      chk(req_ready, "R7", "ready before read", req_ready, 1);
      req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
      @(negedge clk);
      for (int c = 1; c <= T_RD; c++) begin
         if (c == 1) begin
            req_valid = junk; req_write = 1'b1; req_addr = ~addr; req_wdata = 4'h9;
         end
         chk(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R2", "read strobes",
             {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
         chk(mem_addr == addr, "R2", "read address", mem_addr, addr);
         chk(!req_ready, "R7", "ready low in read", req_ready, 0);
         chk(!rd_valid, "R3", "no early rd_valid", rd_valid, 0);
         @(negedge clk);
      end
      for (int c = 1; c <= T_TURN; c++) begin
         chk(mem_cs_n && !mem_dq_oe, "R6", "turnaround quiet",
             {mem_cs_n, mem_dq_oe}, 2'b10);
         chk(!req_ready, "R6", "ready low in turnaround", req_ready, 0);
         chk(rd_valid == (c == 1), "R3", "rd_valid pulse", rd_valid, (c == 1));
         if (c == 1) chk(rd_data == exp, "R3", "read data", rd_data, exp);
         if (c == T_TURN) req_valid = 1'b0;
         @(negedge clk);
      end
      check_idle("R6");
      chk(!rd_valid, "R3", "rd_valid cleared", rd_valid, 0);
   endtask

   task automatic test_standby();
      req_valid = 1'b0;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk(mem_cs_n && req_ready, "R9", "standby while idle", mem_cs_n, 1);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem_model[i] = 4'(i) ^ 4'h5;
         exp_mem[i]   = 4'(i) ^ 4'h5;
      end
      test_reset();
      test_standby();
      do_write(16'h0012, 4'hA, 1'b0);
      do_read (16'h0012, 1'b0);
      do_write(16'h1234, 4'h5, 1'b1);
      do_write(16'hFF00, 4'hF, 1'b0);
      do_write(16'h00FE, 4'h0, 1'b1);
      do_read (16'h1234, 1'b1);
      do_read (16'hFF00, 1'b0);
      do_read (16'h00FE, 1'b0);
      do_read (16'h0077, 1'b1);
      do_read (16'hFFED, 1'b0);
      do_read (16'h00CB, 1'b0);
      do_write(16'h0012, 4'h3, 1'b0);
      do_read (16'h0012, 1'b0);
      test_standby();
      report();
      $finish;
   end

endmodule